// File: doc/BRIEF.md
# Partitionable Dual Stack Pointer Unit

This block keeps the pointers for two hardware stacks, a parameter stack and a return stack. Each stack sits in its own 256-word on-chip memory. A single 16-bit configuration word splits each memory into equal substacks and sets an underflow margin for each stack on its own. For each stack the block takes push and pop requests and a substack-select value, drives the memory address of the current top, and raises sticky overflow and underflow flags. The memory contents are kept outside the block.

The address is built from two parts. The high bits come from the substack select, cut down to as many bits as there are substacks. The low bits come from the pointer, which wraps inside the chosen substack. Writing the configuration word reloads both pointers and clears all flags, so software can re-partition or restart a stack with one write.

Top module: `dual_stack_ptr`

## Requirements
- R1: After reset the configuration word is zero, both pointers are zero, all four flags are low, and each address equals select × 32.
- R2: Configuration layout: bit 0 is the parameter start flag, bits 2:1 the parameter size code, bits 7:3 the parameter underflow limit. Bits 8, 10:9 and 15:11 hold the same three fields for the return stack. Size codes: 00 gives eight 32-word substacks, 01 four of 64, 10 two of 128, 11 one of 256.
- R3: Address = (select mod substack count) × substack size + pointer. Select bits beyond the substack count have no effect.
- R4: A push alone raises the pointer by one, and a pop alone lowers it by one, both modulo the substack size. The new address shows one cycle after the request.
- R5: A push while the pointer equals substack size − 1 sets that stack's overflow flag, and the pointer wraps to 0.
- R6: A pop while the pointer is at or below the underflow limit sets that stack's underflow flag. The pointer still decrements with wrap.
- R7: A configuration write loads each pointer with 0 when its start flag is 1, or with its limit when the flag is 0. It clears all flags. Push and pop in that same cycle are ignored.
- R8: Overflow and underflow flags stay set until the next configuration write.
- R9: Push and pop in the same cycle leave that stack's pointer unchanged and set no flag.
- R10: The two stacks are independent. Requests, select and flags of one never change the other's address or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| ps_push | input | 1 | Parameter stack push |
| ps_pop | input | 1 | Parameter stack pop |
| ps_sel | input | 3 | Parameter substack select |
| ps_addr | output | 8 | Parameter stack memory address |
| ps_unf | output | 1 | Parameter stack underflow flag |
| ps_ovf | output | 1 | Parameter stack overflow flag |
| rs_push | input | 1 | Return stack push |
| rs_pop | input | 1 | Return stack pop |
| rs_sel | input | 3 | Return substack select |
| rs_addr | output | 8 | Return stack memory address |
| rs_unf | output | 1 | Return stack underflow flag |
| rs_ovf | output | 1 | Return stack overflow flag |

## Verification
Every size code is run with both start-flag values, first under push-heavy traffic and then under pop-heavy traffic. Push-heavy traffic drives the pointer across the substack top and shows the overflow wrap. Pop-heavy traffic crosses the limit and the bottom, which separates the underflow test from the plain wrap. Select values are changed at random during these runs, so masking of the surplus select bits shows up at every partition size. Directed sequences cover a push or pop held through a configuration write, simultaneous push and pop, and a full 32-push climb to the top.

// File: rtl/dual_stack_ptr.sv
module dual_stack_ptr #(
  parameter int MINW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2*(MINW+3)-1:0]  cfg_wdata,
  input  logic                   ps_push,
  input  logic                   ps_pop,
  input  logic [2:0]             ps_sel,
  output logic [MINW+2:0]        ps_addr,
  output logic                   ps_unf,
  output logic                   ps_ovf,
  input  logic                   rs_push,
  input  logic                   rs_pop,
  input  logic [2:0]             rs_sel,
  output logic [MINW+2:0]        rs_addr,
  output logic                   rs_unf,
  output logic                   rs_ovf
);
  localparam int AW   = MINW + 3;
  localparam int SLOT = MINW + 3;
  localparam int CW   = 2 * SLOT;

  logic [CW-1:0]        cfg_q;
  logic [1:0]           push_v, pop_v, ovf_v, unf_v;
  logic [1:0][2:0]      sel_v;
  logic [1:0][AW-1:0]   addr_v;

  assign push_v = {rs_push, ps_push};
  assign pop_v  = {rs_pop, ps_pop};
  assign sel_v  = {rs_sel, ps_sel};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;

  for (genvar s = 0; s < 2; s++) begin : g_stk
    logic [1:0]      code;
    logic [MINW-1:0] lim, new_lim;
    logic            new_start;
    logic [AW-1:0]   mask, base, init, ptr_q;
    logic [AW+2:0]   shifted;
    logic            ovf_q, unf_q, up, dn;

    assign code      = cfg_q[s*SLOT+1 +: 2];
    assign lim       = cfg_q[s*SLOT+3 +: MINW];
    assign new_start = cfg_wdata[s*SLOT];
    assign new_lim   = cfg_wdata[s*SLOT+3 +: MINW];
    assign init      = new_start ? '0 : AW'(new_lim);
    assign mask      = {AW{1'b1}} >> (2'd3 - code);
    assign shifted   = {{AW{1'b0}}, sel_v[s]} << (MINW + int'(code));
    assign base      = shifted[AW-1:0];
    assign up        = push_v[s] & ~pop_v[s];
    assign dn        = pop_v[s] & ~push_v[s];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ptr_q <= '0;
        ovf_q <= 1'b0;
        unf_q <= 1'b0;
      end else if (cfg_we) begin
        ptr_q <= init;
        ovf_q <= 1'b0;
        unf_q <= 1'b0;
      end else if (up) begin
        ptr_q <= (ptr_q + 1'b1) & mask;
        if (ptr_q == mask) ovf_q <= 1'b1;
      end else if (dn) begin
        ptr_q <= (ptr_q - 1'b1) & mask;
        if (ptr_q <= AW'(lim)) unf_q <= 1'b1;
      end

    assign addr_v[s] = base | (ptr_q & mask);
    assign ovf_v[s]  = ovf_q;
    assign unf_v[s]  = unf_q;
  end

  assign ps_addr = addr_v[0];
  assign rs_addr = addr_v[1];
  assign ps_ovf  = ovf_v[0];
  assign rs_ovf  = ovf_v[1];
  assign ps_unf  = unf_v[0];
  assign rs_unf  = unf_v[1];
endmodule

// File: rtl/dual_stack_ptr_chk.sv
module dual_stack_ptr_chk #(
  parameter int MINW = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [2*(MINW+3)-1:0] cfg_wdata,
  input logic                  ps_push,
  input logic                  ps_pop,
  input logic [2:0]            ps_sel,
  input logic [MINW+2:0]       ps_addr,
  input logic                  ps_unf,
  input logic                  ps_ovf,
  input logic                  rs_push,
  input logic                  rs_pop,
  input logic [2:0]            rs_sel,
  input logic [MINW+2:0]       rs_addr,
  input logic                  rs_unf,
  input logic                  rs_ovf
);
  assert_hold_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_push && ps_pop && !cfg_we) |=> (!$stable(ps_sel) || $stable(ps_addr)));

  assert_sticky_povf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_ovf && !cfg_we) |=> ps_ovf);

  assert_sticky_runf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_unf && !cfg_we) |=> rs_unf);

  assert_cfg_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!ps_ovf && !ps_unf && !rs_ovf && !rs_unf));

  assert_start_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0] && cfg_wdata[2:1] == 2'b11) |=> (ps_addr == '0));

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_ovf) |-> $past(ps_push && !ps_pop && !cfg_we));

  assert_unf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_unf) |-> $past(rs_pop && !rs_push && !cfg_we));

  assert_independent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_push && !rs_pop && !cfg_we) |=> (!$stable(rs_sel) || $stable(rs_addr)));
endmodule

bind dual_stack_ptr dual_stack_ptr_chk #(.MINW(MINW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .ps_push(ps_push), .ps_pop(ps_pop), .ps_sel(ps_sel), .ps_addr(ps_addr),
  .ps_unf(ps_unf), .ps_ovf(ps_ovf),
  .rs_push(rs_push), .rs_pop(rs_pop), .rs_sel(rs_sel), .rs_addr(rs_addr),
  .rs_unf(rs_unf), .rs_ovf(rs_ovf)
);

// File: tb/dual_stack_ptr_tb.sv
module dual_stack_ptr_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic ps_push = 0, ps_pop = 0, rs_push = 0, rs_pop = 0;
  logic [2:0] ps_sel = '0, rs_sel = '0;
  logic [7:0] ps_addr, rs_addr;
  logic ps_unf, ps_ovf, rs_unf, rs_ovf;

  int checks = 0, errors = 0;
  int mptr [2];
  bit movf [2];
  bit munf [2];
  logic [15:0] mcfg = '0;

  always #(CLK_P/2) clk = ~clk;

  dual_stack_ptr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ps_push(ps_push), .ps_pop(ps_pop), .ps_sel(ps_sel), .ps_addr(ps_addr),
    .ps_unf(ps_unf), .ps_ovf(ps_ovf),
    .rs_push(rs_push), .rs_pop(rs_pop), .rs_sel(rs_sel), .rs_addr(rs_addr),
    .rs_unf(rs_unf), .rs_ovf(rs_ovf)
  );

  function automatic int m_code(int s);  return int'(mcfg[s*8+1 +: 2]); endfunction
  function automatic int m_lim(int s);   return int'(mcfg[s*8+3 +: 5]); endfunction
  function automatic int m_size(int s);  return 32 << m_code(s); endfunction
  function automatic int m_addr(int s, int sel);
    return (sel % (8 >> m_code(s))) * m_size(s) + mptr[s];
  endfunction

  always @(posedge clk) begin
    bit pu, po;
    if (!rst_n) begin
      mcfg = '0;
      for (int s = 0; s < 2; s++) begin mptr[s] = 0; movf[s] = 0; munf[s] = 0; end
    end else if (cfg_we) begin
      mcfg = cfg_wdata;
      for (int s = 0; s < 2; s++) begin
        mptr[s] = mcfg[s*8] ? 0 : m_lim(s);
        movf[s] = 0;
        munf[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        pu = (s == 0) ? ps_push : rs_push;
        po = (s == 0) ? ps_pop  : rs_pop;
        if (pu && !po) begin
          if (mptr[s] == m_size(s) - 1) begin movf[s] = 1; mptr[s] = 0; end
          else mptr[s] = mptr[s] + 1;
        end else if (po && !pu) begin
          if (mptr[s] <= m_lim(s)) munf[s] = 1;
          mptr[s] = (mptr[s] == 0) ? m_size(s) - 1 : mptr[s] - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all;
    chk(ps_addr == m_addr(0, ps_sel), "R3 R4 param address", ps_addr, m_addr(0, ps_sel));
    chk(rs_addr == m_addr(1, rs_sel), "R3 R4 return address", rs_addr, m_addr(1, rs_sel));
    chk(ps_ovf == movf[0], "R5 R8 param overflow", ps_ovf, movf[0]);
    chk(rs_ovf == movf[1], "R5 R8 return overflow", rs_ovf, movf[1]);
    chk(ps_unf == munf[0], "R6 R8 param underflow", ps_unf, munf[0]);
    chk(rs_unf == munf[1], "R6 R8 return underflow", rs_unf, munf[1]);
  endtask

  task automatic tick;
    @(posedge clk);
    #(CLK_P/4);
    compare_all();
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    cfg_we = 1; cfg_wdata = v;
    tick();
    cfg_we = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL R1 watchdog: actual 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    int a;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    rst_n = 1; ps_sel = 3; rs_sel = 5;
    #1;
    chk(ps_addr == 96,  "R1 param address", ps_addr, 96);
    chk(rs_addr == 160, "R1 return address", rs_addr, 160);
    chk({ps_ovf, ps_unf, rs_ovf, rs_unf} == 4'b0, "R1 flags", {ps_ovf, ps_unf, rs_ovf, rs_unf}, 0);

    ps_push = 1;
    wr_cfg(16'h153A);
    ps_push = 0; ps_sel = 6; rs_sel = 3;
    #1;
    chk(ps_addr == 135, "R2 R7 param start at limit", ps_addr, 135);
    chk(rs_addr == 128, "R2 R7 return start at bottom", rs_addr, 128);

    wr_cfg(16'h0001);
    ps_sel = 2; rs_sel = 5; ps_push = 1;
    repeat (31) tick();
    chk(ps_addr == 95 && !ps_ovf, "R5 top before overflow", ps_addr, 95);
    tick();
    chk(ps_ovf == 1, "R5 overflow set", ps_ovf, 1);
    chk(ps_addr == 64, "R5 wrap to bottom", ps_addr, 64);
    ps_push = 0; ps_pop = 1;
    repeat (3) tick();
    ps_pop = 0;
    chk(ps_ovf == 1, "R8 overflow sticky", ps_ovf, 1);

    ps_push = 1; ps_pop = 1; a = ps_addr;
    tick();
    chk(ps_addr == a, "R9 push and pop hold", ps_addr, a);
    ps_push = 0; ps_pop = 0;

    wr_cfg(16'h0019);
    ps_sel = 1; ps_pop = 1;
    tick();
    ps_pop = 0;
    chk(ps_unf == 1, "R6 underflow at limit", ps_unf, 1);
    chk(ps_addr == 63, "R6 pointer wraps", ps_addr, 63);
    chk(rs_addr == 160 && !rs_unf && !rs_ovf, "R10 return untouched", rs_addr, 160);

    wr_cfg(16'h0004);
    ps_sel = 1; #1; a = ps_addr;
    ps_sel = 3; #1;
    chk(ps_addr == a && a == 128, "R3 surplus select bits ignored", ps_addr, 128);
    ps_sel = 0; #1;
    chk(ps_addr == 0, "R3 lower substack", ps_addr, 0);

    for (int code = 0; code < 4; code++) begin
      for (int st = 0; st < 2; st++) begin
        logic [15:0] v;
        v[7:0]  = {5'($urandom_range(0, 31)), 2'(code), 1'(st)};
        v[15:8] = {5'($urandom_range(0, 31)), 2'(3 - code), 1'(1 - st)};
        wr_cfg(v);
        for (int i = 0; i < 150; i++) begin
          bit heavy;
          heavy = (i < 75);
          ps_push = heavy ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
          ps_pop  = heavy ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
          rs_push = heavy ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
          rs_pop  = heavy ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
          if ($urandom_range(0, 7) == 0) ps_sel = 3'($urandom_range(0, 7));
          if ($urandom_range(0, 7) == 0) rs_sel = 3'($urandom_range(0, 7));
          tick();
        end
        ps_push = 0; ps_pop = 0; rs_push = 0; rs_pop = 0;
      end
    end

    finish_run();
  end
endmodule